// File: doc/BRIEF.md
# Generation-Bit Completion Ring Writer

This block is the device-side producer of a completion ring in host memory. Each completion event it accepts carries a 16-bit tag, a length, a direction flag and an end-of-packet flag. The tag is a transmit completion tag or a receive buffer id. The block turns each event into an 8-byte little-endian descriptor and writes it, one 32-bit word at a time, into the next slot of the ring. The block keeps no producer register that the host reads. Instead, each descriptor holds a generation bit that tells the host whether the slot is new.

The host fills every slot with generation 0 before it starts the ring. On its first pass through the ring the block writes generation 1. Each time the write position wraps back to slot 0, the generation the block writes is inverted. The word that holds the generation is always written after the word that holds the tag and length, so a slot never looks valid while it is only half written.

The ring base address and the ring size (as a power of two) are configuration inputs. They must stay stable between resets. The block does not guard against overrunning the host. The host limits how much work it posts so that the ring cannot overflow.

Top module: `cq_gen_writer`

## Requirements
- R1: After reset `ev_ready` is 1 and `mem_valid` is 0. No memory write is issued until an event is accepted.
- R2: The first word of a descriptor carries the tag in bits 15:0 and the length in bits 29:16. Bits 31:30 are 0.
- R3: The second word carries the rx flag in bit 0, the end-of-packet flag in bit 1 and the generation in bit 31. All other bits are 0. This word is written after the first word, and it is the only word issued with `mem_last` set.
- R4: Slot i is written at `cfg_base + 8*i`. Its first word goes to that address and its second word goes to that address plus 4.
- R5: After reset the write position is slot 0 and the generation written is 1.
- R6: After the slot with index 2^`cfg_log2`-1 is written, the next slot is 0 and the generation written is inverted. This repeats on every wrap.
- R7: While `mem_valid` is 1 and `mem_ready` is 0, the address, data and `mem_last` do not change, and `mem_valid` stays 1.
- R8: Only one event is in flight at a time. `ev_ready` is 0 while either word of a descriptor is pending.
- R9: The ring size follows `cfg_log2`, which is sampled per slot. Different sizes give different wrap points.
- R10: A receive packet split over several descriptors occupies consecutive slots, and the end-of-packet flag of each descriptor is written exactly as the event gives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Completion event offered |
| ev_ready | output | 1 | Block can take an event |
| ev_tag | input | 16 | Completion tag or buffer id |
| ev_len | input | 14 | Byte length |
| ev_rx | input | 1 | 1 for a receive completion |
| ev_eop | input | 1 | Last descriptor of a packet |
| cfg_base | input | 32 | Ring base byte address, 8-byte aligned |
| cfg_log2 | input | 4 | Log2 of the slot count |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 32 | Byte address of the word |
| mem_data | output | 32 | Word data, byte 0 in bits 7:0 |
| mem_last | output | 1 | Word carries the generation bit |

## Verification
A wrong slot index shows up on the very next write as a wrong `mem_addr`. A generation register that fails to flip, or flips at the wrong time, only shows up on the first write after a wrap. So the stimulus crosses the wrap point several times, with two ring sizes. If the word order were swapped, or a field landed on the wrong bit, the first descriptor written would already differ from the bench's model. Stalls on `mem_ready` check that a held request does not move or get counted twice.

// File: rtl/cqw_pkg.sv
package cqw_pkg;
  parameter int unsigned CQW_ADDR_W   = 32;
  parameter int unsigned CQW_WORD_W   = 32;
  parameter int unsigned CQW_TAG_W    = 16;
  parameter int unsigned CQW_LEN_W    = 14;
  parameter int unsigned CQW_MAX_LOG2 = 12;
  parameter int unsigned CQW_DESC_B   = 8;
  parameter int unsigned CQW_GEN_BIT  = 31;

  typedef struct packed {
    logic [CQW_TAG_W-1:0] tag;
    logic [CQW_LEN_W-1:0] len;
    logic                 rx;
    logic                 eop;
  } cq_event_t;

  function automatic logic [CQW_WORD_W-1:0] pack_lo(cq_event_t e);
    logic [CQW_WORD_W-1:0] w;
    w = '0;
    w[CQW_TAG_W-1:0] = e.tag;
    w[CQW_TAG_W +: CQW_LEN_W] = e.len;
    return w;
  endfunction

  function automatic logic [CQW_WORD_W-1:0] pack_hi(cq_event_t e, logic gen);
    logic [CQW_WORD_W-1:0] w;
    w = '0;
    w[0] = e.rx;
    w[1] = e.eop;
    w[CQW_GEN_BIT] = gen;
    return w;
  endfunction

  function automatic logic [CQW_ADDR_W-1:0] slot_addr(logic [CQW_ADDR_W-1:0] base,
                                                      logic [CQW_MAX_LOG2-1:0] idx,
                                                      logic hi);
    logic [CQW_ADDR_W-1:0] off;
    off = CQW_ADDR_W'(idx) * CQW_ADDR_W'(CQW_DESC_B);
    if (hi) off = off + CQW_ADDR_W'(CQW_DESC_B / 2);
    return base + off;
  endfunction

  function automatic logic [CQW_MAX_LOG2-1:0] last_index(logic [3:0] lg);
    logic [CQW_MAX_LOG2:0] n;
    int unsigned l;
    l = (int'(lg) > int'(CQW_MAX_LOG2)) ? CQW_MAX_LOG2 : int'(lg);
    n = (CQW_MAX_LOG2+1)'(1) << l;
    return CQW_MAX_LOG2'(n - 1'b1);
  endfunction
endpackage

// File: rtl/cqw_slot_tracker.sv
module cqw_slot_tracker
  import cqw_pkg::*;
#(
  parameter int unsigned MAX_LOG2 = CQW_MAX_LOG2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          log2,
  input  logic                advance,
  output logic [MAX_LOG2-1:0] idx,
  output logic                gen,
  output logic                wrap_evt
);
  logic [MAX_LOG2-1:0] last_idx;

  assign last_idx = last_index(log2);
  assign wrap_evt = advance && (idx >= last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      gen <= 1'b1;
    end else if (advance) begin
      if (wrap_evt) begin
        idx <= '0;
        gen <= ~gen;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  p_gen_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (gen != $past(gen)) && (idx == '0));
  p_gen_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wrap_evt) |=> (gen == $past(gen)) && (idx == $past(idx) + 1'b1));
  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(log2) |-> (idx <= last_idx));
endmodule

// File: rtl/cqw_desc_packer.sv
module cqw_desc_packer
  import cqw_pkg::*;
(
  input  cq_event_t             ev,
  input  logic                  gen,
  input  logic                  sel_hi,
  output logic [CQW_WORD_W-1:0] word
);
  logic [CQW_WORD_W-1:0] lo_w;
  logic [CQW_WORD_W-1:0] hi_w;

  assign lo_w = pack_lo(ev);
  assign hi_w = pack_hi(ev, gen);
  assign word = sel_hi ? hi_w : lo_w;

  always_comb begin
    if (!sel_hi) assert (word[CQW_GEN_BIT] == 1'b0); // R2 first word never holds a generation
  end
endmodule

// File: rtl/cq_gen_writer.sv
module cq_gen_writer
  import cqw_pkg::*;
#(
  parameter int unsigned ADDR_W   = CQW_ADDR_W,
  parameter int unsigned MAX_LOG2 = CQW_MAX_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [15:0]       ev_tag,
  input  logic [13:0]       ev_len,
  input  logic              ev_rx,
  input  logic              ev_eop,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [3:0]        cfg_log2,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data,
  output logic              mem_last
);
  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI} wr_state_t;

  wr_state_t           state;
  cq_event_t           ev_q;
  logic                accept;
  logic                lo_done;
  logic                hi_done;
  logic [MAX_LOG2-1:0] slot_idx;
  logic                slot_gen;
  logic                slot_wrap;

  assign accept   = ev_valid && ev_ready;
  assign lo_done  = (state == ST_LO) && mem_ready;
  assign hi_done  = (state == ST_HI) && mem_ready;
  assign ev_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ev_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_LO;
          ev_q  <= '{tag: ev_tag, len: ev_len, rx: ev_rx, eop: ev_eop};
        end
        ST_LO:   if (lo_done) state <= ST_HI;
        ST_HI:   if (hi_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  cqw_slot_tracker #(.MAX_LOG2(MAX_LOG2)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .log2     (cfg_log2),
    .advance  (hi_done),
    .idx      (slot_idx),
    .gen      (slot_gen),
    .wrap_evt (slot_wrap)
  );

  cqw_desc_packer u_pack (
    .ev     (ev_q),
    .gen    (slot_gen),
    .sel_hi (state == ST_HI),
    .word   (mem_data)
  );

  assign mem_valid = (state != ST_IDLE);
  assign mem_last  = (state == ST_HI);
  assign mem_addr  = ADDR_W'(slot_addr(CQW_ADDR_W'(cfg_base), slot_idx, state == ST_HI));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_last));
  p_one_flight_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !ev_ready);
  p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_last && mem_ready) |=> (mem_valid && mem_last));
  p_hi_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_last) |-> mem_addr[2]);
  p_slot_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_last && mem_ready) |=> !mem_valid);
endmodule

// File: tb/sim_cq_gen_writer.sv
module sim_cq_gen_writer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_valid;
  logic        ev_ready;
  logic [15:0] ev_tag;
  logic [13:0] ev_len;
  logic        ev_rx;
  logic        ev_eop;
  logic [31:0] cfg_base;
  logic [3:0]  cfg_log2;
  logic        mem_valid;
  logic        mem_ready;
  logic [31:0] mem_addr;
  logic [31:0] mem_data;
  logic        mem_last;

  int n_run = 0;
  int n_fail = 0;
  bit stall_on = 0;
  int cyc = 0;

  logic [31:0] q_addr[$];
  logic [31:0] q_data[$];
  logic        q_last[$];

  int   m_idx;
  logic m_gen;

  always #10 clk = ~clk;

  cq_gen_writer u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_tag(ev_tag), .ev_len(ev_len), .ev_rx(ev_rx), .ev_eop(ev_eop),
    .cfg_base(cfg_base), .cfg_log2(cfg_log2), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_last(mem_last)
  );

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // mem_ready pattern, changed on the falling edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    mem_ready <= stall_on ? ((cyc % 3) == 2) : 1'b1;
  end

  // monitor: compares every transfer with the scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n && mem_valid) begin
      check(!ev_ready, "R8 ready while busy", {63'd0, ev_ready}, 64'd0);
      if (mem_ready) begin
        if (q_addr.size() == 0) begin
          check(1'b0, "R1 R3 unexpected write", {32'd0, mem_addr}, 64'd0);
        end else begin
          logic [31:0] ea, ed;
          logic el;
          ea = q_addr.pop_front();
          ed = q_data.pop_front();
          el = q_last.pop_front();
          check(mem_addr == ea, "R4 R6 R9 address", {32'd0, mem_addr}, {32'd0, ea});
          check(mem_data == ed, el ? "R3 R5 R6 R10 second word" : "R2 first word",
                {32'd0, mem_data}, {32'd0, ed});
          check(mem_last == el, "R3 last flag", {63'd0, mem_last}, {63'd0, el});
        end
      end
    end
  end

  task automatic send(input logic [15:0] tag, input logic [13:0] len,
                      input logic rx, input logic eop);
    logic [31:0] a;
    a = cfg_base + 32'(m_idx * 8);
    q_addr.push_back(a);
    q_data.push_back({2'b00, len, tag});
    q_last.push_back(1'b0);
    q_addr.push_back(a + 32'd4);
    q_data.push_back({m_gen, 29'd0, eop, rx});
    q_last.push_back(1'b1);
    if (m_idx == (1 << cfg_log2) - 1) begin
      m_idx = 0;
      m_gen = ~m_gen;
    end else begin
      m_idx++;
    end
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    ev_valid = 1'b1; ev_tag = tag; ev_len = len; ev_rx = rx; ev_eop = eop;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((q_addr.size() != 0 || mem_valid) && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check(q_addr.size() == 0, "R3 R4 missing writes", 64'(q_addr.size()), 64'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_idx = 0;
    m_gen = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    ev_valid = 0; ev_tag = 0; ev_len = 0; ev_rx = 0; ev_eop = 0;
    cfg_base = 32'h0001_0040; cfg_log2 = 4'd2; mem_ready = 1'b1;
    do_reset();
    @(negedge clk);
    // R1 reset state
    check(ev_ready == 1'b1, "R1 ev_ready", {63'd0, ev_ready}, 64'd1);
    check(mem_valid == 1'b0, "R1 mem_valid", {63'd0, mem_valid}, 64'd0);
    repeat (4) @(negedge clk);
    check(mem_valid == 1'b0, "R1 idle stays quiet", {63'd0, mem_valid}, 64'd0);

    // R5 R6: four-slot ring, ten events, two wraps
    for (int i = 0; i < 10; i++)
      send(16'hA000 + 16'(i), 14'(i * 97 + 3), 1'b0, 1'b1);
    drain();

    // R9 R10: eight-slot ring, stalls, multi-descriptor receive packets
    cfg_base = 32'h8000_0100; cfg_log2 = 4'd3; stall_on = 1;
    do_reset();
    for (int p = 0; p < 6; p++)
      for (int d = 0; d < 3; d++)
        send(16'h0F00 + 16'(p * 3 + d), 14'h3FFF - 14'(d), 1'b1, d == 2);
    send(16'hFFFF, 14'h3FFF, 1'b0, 1'b0);
    drain();
    stall_on = 0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule